// File: doc/BRIEF.md
# Bridge Delayed Write Controller

This block is the slave-side controller of a bus bridge for writes that may not be posted. I/O writes, configuration writes, and memory writes made while posting is switched off are all handled as delayed transactions. Each write attempt arrives as a single-cycle request carrying command, address, data and two parity bits. The block checks the address against an inclusive base/limit window. If the single queue entry is free, it stores the command, address and data, tells the master to retry, and hands the stored write to the target-side port through a level request that stays up until that port signals completion with a status code.

The master repeats the same write. On each repeat the block decides the answer from four things: whether the command and address match the stored entry, whether the target side has finished, whether the data matches the stored data, and the parity results. When the repeat matches fully and has clean parity, the block returns the status the target reported, with no change, signals a disconnect, and frees the entry. Parity failures can produce a system-error pulse (address) or a parity-error pulse (data), each under its own enable.

Top module: `bridge_dwr_ctrl`

## Requirements
- R1: A write attempt is accepted when all of the following hold: the address satisfies base <= address <= limit, the entry is free, and the command is 4'b0011 (I/O write), 4'b1011 (configuration write), or 4'b0111 (memory write) with cfg_posting_en low. Acceptance gives response code 2'b01 (retry) in the cycle after the request, and the entry is captured.
- R2: These attempts get response code 2'b00 (no claim) and leave the entry and the target port unchanged: an address outside the window, any other command, or a memory write while posting is enabled.
- R3: Parity is even, so an address parity error means the XOR of {cmd, addr, addr parity bit} is 1. With checking enabled, such an error on an eligible attempt gives code 2'b00 and captures nothing. serr_o pulses with that response only when cfg_serr_en and cfg_primary are both high.
- R4: A data parity error means the XOR of {data, data parity bit} is 1. With checking enabled, such an error on an eligible attempt against a free entry gives code 2'b10 (claim) and captures nothing. perr_o pulses only when cfg_perr_en is high.
- R5: Once an entry is captured, t_req is high in the cycle after the retry response. t_cmd, t_addr and t_data hold the stored values and stay stable until t_done. The t_status value given with t_done is recorded, and t_req drops in the next cycle.
- R6: While the entry is occupied, an eligible attempt whose command or address differs from the stored one gets code 2'b01. So does any eligible attempt made before the target has completed. The entry is kept in both cases.
- R7: After completion, a matching attempt with equal data and good parity gets code 2'b11 (disconnect). rsp_status then equals the recorded target status exactly: 2'b00 normal, 2'b01 target-abort, 2'b10 parity error. The entry is then freed. rsp_status is 0 with every other code.
- R8: After completion, a matching attempt with a data parity error gets code 2'b10. perr_o pulses if it is enabled, and the entry stays enqueued.
- R9: After completion, a matching attempt whose data differs from the stored data, with good parity, gets code 2'b01, and the entry stays enqueued.
- R10: While rst_n is low at a clock edge, the entry is cleared and all outputs are 0.
- R11: With cfg_par_chk_en low, parity bits are ignored: no claim or no-claim comes from parity, and neither perr_o nor serr_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | Window lower bound, inclusive |
| cfg_limit | input | AW | Window upper bound, inclusive |
| cfg_posting_en | input | 1 | Memory writes are posted elsewhere, not handled here |
| cfg_par_chk_en | input | 1 | Enable parity checking and response |
| cfg_perr_en | input | 1 | Enable the parity-error pulse |
| cfg_serr_en | input | 1 | Enable the system-error pulse |
| cfg_primary | input | 1 | This port is the primary side |
| i_req | input | 1 | One-cycle write attempt strobe |
| i_cmd | input | CW | Attempt command |
| i_addr | input | AW | Attempt address |
| i_data | input | DW | Attempt data |
| i_apar | input | 1 | Even parity bit over command and address |
| i_dpar | input | 1 | Even parity bit over data |
| rsp_valid | output | 1 | Response strobe, one cycle after i_req |
| rsp_code | output | 2 | 00 no claim, 01 retry, 10 claim, 11 disconnect |
| rsp_status | output | 2 | Target status returned with disconnect |
| perr_o | output | 1 | Data parity error pulse |
| serr_o | output | 1 | System error pulse |
| t_req | output | 1 | Target-side request, held until t_done |
| t_cmd | output | CW | Stored command |
| t_addr | output | AW | Stored address |
| t_data | output | DW | Stored data |
| t_done | input | 1 | Target-side completion strobe |
| t_status | input | 2 | Completion status from target side |

## Verification
The assertions rely on four properties of the inputs. t_done is raised only while t_req is high. Configuration inputs do not change between a request and its response. i_req strobes are single cycles. t_status carries one of the three defined codes. The stimulus meets these by writing configuration only while no request is outstanding, by pulsing t_done for a single cycle only after t_req has been seen high, and by separating each attempt from the next with idle cycles.

// File: rtl/dwc_pkg.sv
// Package: shared response/entry types and the command codes that may be
// deferred. Assumes 4-bit bus commands.
package dwc_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_RETRY = 2'b01,
        RSP_CLAIM = 2'b10,
        RSP_DISC  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        ENT_FREE = 2'b00,
        ENT_PEND = 2'b01,
        ENT_DONE = 2'b10
    } ent_e;

    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

endpackage

// File: rtl/dwc_decode.sv
// Decoder: window hit, eligibility of the command for deferral, and parity
// error flags (gated by the check enable). Purely combinational; assumes
// even parity over {cmd,addr} and over data.
module dwc_decode
    import dwc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          posting_en,
    input  logic          chk_en,
    input  logic [CW-1:0] cmd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          apar,
    input  logic          dpar,
    output logic          eligible,
    output logic          aperr,
    output logic          dperr
);

    logic in_win;
    logic dly_cmd;

    // Window compare and command class.
    always_comb begin
        in_win  = (addr >= base) && (addr <= limit);
        dly_cmd = (cmd == CMD_IO_WR) || (cmd == CMD_CFG_WR) ||
                  ((cmd == CMD_MEM_WR) && !posting_en);
        eligible = in_win && dly_cmd;
    end

    // Parity checks, reported only while checking is enabled.
    always_comb begin
        aperr = chk_en && (^{cmd, addr, apar});
        dperr = chk_en && (^{data, dpar});
    end

endmodule

// File: rtl/dwc_entry.sv
// Single delayed-write entry: holds command, address and data, drives the
// target-side request until completion, keeps the completion status until
// released. Assumes t_done only arrives while t_req is high.
module dwc_entry
    import dwc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          release_e,
    input  logic [CW-1:0] in_cmd,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          t_done,
    input  logic [1:0]    t_status,
    output logic          busy,
    output logic          done,
    output logic          hit,
    output logic          dhit,
    output logic [1:0]    stat,
    output logic          t_req,
    output logic [CW-1:0] t_cmd,
    output logic [AW-1:0] t_addr,
    output logic [DW-1:0] t_data
);

    ent_e          state;
    logic [CW-1:0] cmd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [1:0]    stat_q;

    // Entry state machine and stored fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENT_FREE;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            stat_q <= '0;
        end else begin
            case (state)
                ENT_FREE: if (capture) begin
                    state  <= ENT_PEND;
                    cmd_q  <= in_cmd;
                    addr_q <= in_addr;
                    data_q <= in_data;
                end
                ENT_PEND: if (t_done) begin
                    state  <= ENT_DONE;
                    stat_q <= t_status;
                end
                ENT_DONE: if (release_e) begin
                    state  <= ENT_FREE;
                    stat_q <= '0;
                end
                default: state <= ENT_FREE;
            endcase
        end
    end

    // Status and match flags toward the responder.
    always_comb begin
        busy  = (state != ENT_FREE);
        done  = (state == ENT_DONE);
        hit   = busy && (cmd_q == in_cmd) && (addr_q == in_addr);
        dhit  = (data_q == in_data);
        stat  = stat_q;
        t_req = (state == ENT_PEND);
        t_cmd  = cmd_q;
        t_addr = addr_q;
        t_data = data_q;
    end

    AST_TREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        t_req && !t_done |=> t_req); // R5
    AST_TFIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        t_req && !t_done |=> $stable(t_addr) && $stable(t_data) && $stable(t_cmd)); // R5
    AST_TREQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        t_req && t_done |=> !t_req); // R5
    AST_CAPTURE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !busy); // R1

endmodule

// File: rtl/dwc_resp.sv
// Responder: decides the answer to each attempt from decode flags and entry
// state, issues capture/release to the entry and registers the response one
// cycle after the request. Assumes single-cycle i_req strobes.
module dwc_resp
    import dwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_req,
    input  logic       eligible,
    input  logic       aperr,
    input  logic       dperr,
    input  logic       busy,
    input  logic       done,
    input  logic       hit,
    input  logic       dhit,
    input  logic [1:0] stat,
    input  logic       perr_en,
    input  logic       serr_en,
    input  logic       primary,
    output logic       capture,
    output logic       release_e,
    output logic       rsp_valid,
    output logic [1:0] rsp_code,
    output logic [1:0] rsp_status,
    output logic       perr_o,
    output logic       serr_o
);

    rsp_e code_d;
    logic perr_d;
    logic serr_d;

    // Per-attempt decision tree.
    always_comb begin
        code_d    = RSP_NONE;
        perr_d    = 1'b0;
        serr_d    = 1'b0;
        capture   = 1'b0;
        release_e = 1'b0;
        if (i_req && eligible) begin
            if (aperr) begin
                serr_d = serr_en && primary;
            end else if (!busy) begin
                if (dperr) begin
                    code_d = RSP_CLAIM;
                    perr_d = perr_en;
                end else begin
                    code_d  = RSP_RETRY;
                    capture = 1'b1;
                end
            end else if (!hit || !done) begin
                code_d = RSP_RETRY;
            end else if (dperr) begin
                code_d = RSP_CLAIM;
                perr_d = perr_en;
            end else if (!dhit) begin
                code_d = RSP_RETRY;
            end else begin
                code_d    = RSP_DISC;
                release_e = 1'b1;
            end
        end
    end

    // Registered response toward the initiating master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code   <= 2'b00;
            rsp_status <= 2'b00;
            perr_o     <= 1'b0;
            serr_o     <= 1'b0;
        end else begin
            rsp_valid  <= i_req;
            rsp_code   <= code_d;
            rsp_status <= (code_d == RSP_DISC) ? stat : 2'b00;
            perr_o     <= perr_d;
            serr_o     <= serr_d;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        i_req |=> rsp_valid); // R1
    AST_STATUS_DISC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 2'b11) |-> (rsp_status == 2'b00)); // R7
    AST_SERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> rsp_valid && (rsp_code == 2'b00) && $past(serr_en && primary)); // R3
    AST_PERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> rsp_valid && (rsp_code == 2'b10) && $past(perr_en)); // R4

endmodule

// File: rtl/bridge_dwr_ctrl.sv
// Top: delayed write controller for a bridge slave port. Wires decoder,
// responder and single entry. Assumes configuration is quasi-static and the
// target side pulses t_done only while t_req is high.
module bridge_dwr_ctrl
    import dwc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic          cfg_posting_en,
    input  logic          cfg_par_chk_en,
    input  logic          cfg_perr_en,
    input  logic          cfg_serr_en,
    input  logic          cfg_primary,
    input  logic          i_req,
    input  logic [CW-1:0] i_cmd,
    input  logic [AW-1:0] i_addr,
    input  logic [DW-1:0] i_data,
    input  logic          i_apar,
    input  logic          i_dpar,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [1:0]    rsp_status,
    output logic          perr_o,
    output logic          serr_o,
    output logic          t_req,
    output logic [CW-1:0] t_cmd,
    output logic [AW-1:0] t_addr,
    output logic [DW-1:0] t_data,
    input  logic          t_done,
    input  logic [1:0]    t_status
);

    logic       eligible, aperr, dperr;
    logic       busy, done, hit, dhit;
    logic [1:0] stat;
    logic       capture, release_e;

    dwc_decode #(.AW(AW), .DW(DW), .CW(CW)) u_dec (
        .base(cfg_base), .limit(cfg_limit), .posting_en(cfg_posting_en),
        .chk_en(cfg_par_chk_en), .cmd(i_cmd), .addr(i_addr), .data(i_data),
        .apar(i_apar), .dpar(i_dpar), .eligible(eligible), .aperr(aperr),
        .dperr(dperr)
    );

    dwc_resp u_rsp (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .eligible(eligible),
        .aperr(aperr), .dperr(dperr), .busy(busy), .done(done), .hit(hit),
        .dhit(dhit), .stat(stat), .perr_en(cfg_perr_en),
        .serr_en(cfg_serr_en), .primary(cfg_primary), .capture(capture),
        .release_e(release_e), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_status(rsp_status), .perr_o(perr_o), .serr_o(serr_o)
    );

    dwc_entry #(.AW(AW), .DW(DW), .CW(CW)) u_ent (
        .clk(clk), .rst_n(rst_n), .capture(capture), .release_e(release_e),
        .in_cmd(i_cmd), .in_addr(i_addr), .in_data(i_data), .t_done(t_done),
        .t_status(t_status), .busy(busy), .done(done), .hit(hit), .dhit(dhit),
        .stat(stat), .t_req(t_req), .t_cmd(t_cmd), .t_addr(t_addr),
        .t_data(t_data)
    );

    AST_DISC_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_code == 2'b11) |-> !busy); // R7
    AST_NOCLAIM_NO_TREQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_code == 2'b00) && !$past(busy) |-> !t_req); // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !t_req && !perr_o && !serr_o); // R10

endmodule

// File: tb/sim_bridge_dwr_ctrl.sv
module sim_bridge_dwr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h1000, cfg_limit = 32'h1FFF;
    logic        cfg_posting_en = 1'b0, cfg_par_chk_en = 1'b1;
    logic        cfg_perr_en = 1'b1, cfg_serr_en = 1'b1, cfg_primary = 1'b1;
    logic        i_req = 1'b0;
    logic [3:0]  i_cmd = '0;
    logic [31:0] i_addr = '0, i_data = '0;
    logic        i_apar = 1'b0, i_dpar = 1'b0;
    logic        rsp_valid, perr_o, serr_o, t_req;
    logic [1:0]  rsp_code, rsp_status;
    logic [3:0]  t_cmd;
    logic [31:0] t_addr, t_data;
    logic        t_done = 1'b0;
    logic [1:0]  t_status = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] code;
        logic [1:0] stat;
        logic       perr;
        logic       serr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bridge_dwr_ctrl u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one attempt, expected answer pushed to the scoreboard.
    task automatic issue(input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] d, input bit abad, input bit dbad,
                         input logic [1:0] ecode, input logic [1:0] estat,
                         input bit eperr, input bit eserr, input string tag);
        exp_t e;
        e.code = ecode; e.stat = estat; e.perr = eperr; e.serr = eserr; e.tag = tag;
        @(negedge clk);
        sb.push_back(e);
        i_req  = 1'b1; i_cmd = c; i_addr = a; i_data = d;
        i_apar = (^{c, a}) ^ abad;
        i_dpar = (^d) ^ dbad;
        @(negedge clk);
        i_req = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "unexpected response", {62'd0, rsp_code}, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_code == e.code, {e.tag, " code"}, {62'd0, rsp_code}, {62'd0, e.code});
                chk(rsp_status == e.stat, {e.tag, " status"}, {62'd0, rsp_status}, {62'd0, e.stat});
                chk(perr_o == e.perr, {e.tag, " perr"}, {63'd0, perr_o}, {63'd0, e.perr});
                chk(serr_o == e.serr, {e.tag, " serr"}, {63'd0, serr_o}, {63'd0, e.serr});
            end
        end
    end

    task automatic complete(input logic [1:0] st);
        @(negedge clk);
        t_done = 1'b1; t_status = st;
        @(negedge clk);
        t_done = 1'b0; t_status = '0;
        chk(t_req == 1'b0, "R5 t_req drops after done", {63'd0, t_req}, 64'd0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk(!rsp_valid && !t_req && !perr_o && !serr_o, "R10 reset outputs",
            {60'd0, rsp_valid, t_req, perr_o, serr_o}, 64'd0);
        rst_n = 1'b1;
        idle(1);

        // R2: not eligible
        issue(4'b0011, 32'h2000, 32'h1, 0, 0, 2'b00, 2'b00, 0, 0, "R2 above limit");
        issue(4'b0011, 32'h0FFF, 32'h1, 0, 0, 2'b00, 2'b00, 0, 0, "R2 below base");
        issue(4'b0110, 32'h1004, 32'h1, 0, 0, 2'b00, 2'b00, 0, 0, "R2 read command");
        cfg_posting_en = 1'b1;
        issue(4'b0111, 32'h1004, 32'h1, 0, 0, 2'b00, 2'b00, 0, 0, "R2 posted memory write");
        cfg_posting_en = 1'b0;
        chk(!t_req, "R2 no target request", {63'd0, t_req}, 64'd0);

        // R3: address parity
        issue(4'b0011, 32'h1004, 32'h5, 1, 0, 2'b00, 2'b00, 0, 1, "R3 addr parity primary");
        cfg_primary = 1'b0;
        issue(4'b0011, 32'h1004, 32'h5, 1, 0, 2'b00, 2'b00, 0, 0, "R3 addr parity secondary");
        cfg_primary = 1'b1;
        chk(!t_req, "R3 nothing captured", {63'd0, t_req}, 64'd0);

        // R4: data parity on free entry
        issue(4'b0011, 32'h1004, 32'h5, 0, 1, 2'b10, 2'b00, 1, 0, "R4 data parity");
        cfg_perr_en = 1'b0;
        issue(4'b0011, 32'h1004, 32'h5, 0, 1, 2'b10, 2'b00, 0, 0, "R4 data parity perr off");
        cfg_perr_en = 1'b1;
        chk(!t_req, "R4 nothing captured", {63'd0, t_req}, 64'd0);

        // R1 / R5: accept and present
        issue(4'b0011, 32'h1004, 32'hA5A5_5A5A, 0, 0, 2'b01, 2'b00, 0, 0, "R1 accept io write");
        chk(t_req, "R5 t_req high", {63'd0, t_req}, 64'd1);
        chk(t_addr == 32'h1004, "R5 t_addr", {32'd0, t_addr}, 64'h1004);
        chk(t_data == 32'hA5A5_5A5A, "R5 t_data", {32'd0, t_data}, 64'hA5A5_5A5A);
        chk(t_cmd == 4'b0011, "R5 t_cmd", {60'd0, t_cmd}, 64'h3);

        // R6: pending
        issue(4'b0011, 32'h1004, 32'hA5A5_5A5A, 0, 0, 2'b01, 2'b00, 0, 0, "R6 repeat before done");
        issue(4'b0011, 32'h1008, 32'h7, 0, 0, 2'b01, 2'b00, 0, 0, "R6 other address");
        issue(4'b1011, 32'h1004, 32'hA5A5_5A5A, 0, 0, 2'b01, 2'b00, 0, 0, "R6 other command");
        issue(4'b0011, 32'h3000, 32'h7, 0, 0, 2'b00, 2'b00, 0, 0, "R2 outside while busy");
        chk(t_req && t_addr == 32'h1004, "R6 entry kept", {32'd0, t_addr}, 64'h1004);

        complete(2'b01);
        issue(4'b0011, 32'h1008, 32'h7, 0, 0, 2'b01, 2'b00, 0, 0, "R6 mismatch after done");
        issue(4'b0011, 32'h1004, 32'h1111, 0, 0, 2'b01, 2'b00, 0, 0, "R9 data differs");
        issue(4'b0011, 32'h1004, 32'hA5A5_5A5A, 0, 1, 2'b10, 2'b00, 1, 0, "R8 matching parity err");
        issue(4'b0011, 32'h1004, 32'hA5A5_5A5A, 0, 0, 2'b11, 2'b01, 0, 0, "R7 target abort status");

        // R1 boundary: limit, config write
        issue(4'b1011, 32'h1FFF, 32'h42, 0, 0, 2'b01, 2'b00, 0, 0, "R1 accept at limit");
        chk(t_req && t_cmd == 4'b1011, "R5 config write presented", {60'd0, t_cmd}, 64'hB);
        complete(2'b10);
        issue(4'b1011, 32'h1FFF, 32'h42, 0, 0, 2'b11, 2'b10, 0, 0, "R7 parity error status");

        // R1 boundary: base, memory write no posting
        issue(4'b0111, 32'h1000, 32'h99, 0, 0, 2'b01, 2'b00, 0, 0, "R1 accept mem write at base");
        complete(2'b00);
        issue(4'b0111, 32'h1000, 32'h99, 0, 0, 2'b11, 2'b00, 0, 0, "R7 normal status");

        // R11: checking disabled
        cfg_par_chk_en = 1'b0;
        issue(4'b0011, 32'h1100, 32'h33, 1, 1, 2'b01, 2'b00, 0, 0, "R11 parity ignored accept");
        complete(2'b00);
        issue(4'b0011, 32'h1100, 32'h33, 1, 1, 2'b11, 2'b00, 0, 0, "R11 parity ignored disconnect");
        cfg_par_chk_en = 1'b1;

        // R10: reset while busy clears entry
        issue(4'b0011, 32'h1200, 32'h44, 0, 0, 2'b01, 2'b00, 0, 0, "R1 accept before reset");
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        chk(!t_req && !rsp_valid, "R10 reset clears entry", {62'd0, t_req, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        issue(4'b0011, 32'h1300, 32'h55, 0, 0, 2'b01, 2'b00, 0, 0, "R10 free after reset");

        idle(3);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule